// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This engine stores an incoming byte stream into buffers that software provides through a ring of receive descriptors held in shared memory. Each descriptor is 8 bytes long. Its first 32-bit word carries a 16-bit status/flags half in bits [15:0] and a 16-bit byte count in bits [31:16]. Its second word, at +4, is the buffer pointer. The engine reads a descriptor, checks that software has marked it empty, and then writes the arriving bytes into that buffer, one byte-lane write per byte.

A buffer is closed when the byte count reaches the maximum length latched for it, when a byte carries a frame-end or error marker, or when a close command arrives. On closing, the engine writes the count and updated flags back into the first word of the descriptor. It then moves to the next descriptor, or returns to the ring base after a descriptor whose wrap flag is set. When the next descriptor is still owned by software, the engine reports busy, discards the bytes that arrive, and polls that descriptor until it is released.

Top module: `rx_bd_ring`

## Requirements
- R1: While `cfg_enable` is low after reset, no memory request is issued. Once it is enabled, the first descriptor word read is at `cfg_ring_base` with its low three bits forced to zero. Each later descriptor is the one 8 bytes above the previous one. The status/flags half sits in bits [15:0] and the count in bits [31:16] of the word at +0, and the buffer pointer is the word at +4.
- R2: After a descriptor with wrap flag bit 14 set has been closed, the next descriptor is the one at the ring base.
- R3: Byte k of a buffer goes to pointer+k through a write with exactly one byte enable set. No byte is written beyond the closed count.
- R4: A buffer closes as soon as it holds the latched maximum length, and the following bytes of the same frame fill the next buffer.
- R5: A byte with `in_last` set is stored and closes the buffer with the last-in-frame flag (bit 10) set.
- R6: A byte with `in_err` set is stored and closes the buffer with the error flag (bit 2) set and bit 10 clear.
- R7: The maximum length is sampled from `cfg_max_len` when a descriptor is fetched. A change while that buffer is filling takes effect only from a later descriptor.
- R8: A `close_req` pulse closes a partly filled buffer with its current count, and reception continues in the next descriptor. A `close_req` while the buffer holds no bytes has no effect.
- R9: When `close_req` coincides with an accepted byte, that byte is included and the buffer closes exactly once, even if the byte also reaches the length limit or carries the frame-end marker.
- R10: The write-back clears the empty flag (bit 15), stores the count, and leaves every status bit other than 15, 10 and 2 unchanged.
- R11: If the fetched descriptor has bit 15 clear, `busy` rises and `in_ready` stays high. Arriving bytes are then discarded, with no memory write. The descriptor is re-read until it is marked empty, and then filling resumes with the bytes that follow.
- R12: After reset, `mem_req`, `in_ready` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Starts descriptor processing at the ring base |
| cfg_ring_base | input | AW | Byte address of the first descriptor (low 3 bits ignored) |
| cfg_max_len | input | 16 | Maximum bytes per buffer, sampled at each descriptor fetch |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte ends a frame |
| in_err | input | 1 | Byte ends on an error |
| in_ready | output | 1 | Byte accepted (stored, or discarded while busy) |
| close_req | input | 1 | Close the partly filled buffer |
| busy | output | 1 | No empty descriptor available; bytes are discarded |
| mem_req | output | 1 | Memory access request, one cycle read latency |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A close command can land in the same cycle as a byte that reaches the length limit, or as a byte carrying the frame-end marker. Both coincidences are provoked by holding `close_req` high during that byte's handshake. The outcome is judged from memory. Exactly one descriptor must be written back, with the byte counted, the limit-sized or short count, and the correct last-in-frame flag. The following descriptor must stay untouched until the next frame, which then lands in it intact. A sweep of every frame length from 1 to three full buffers checks the arithmetic split into buffers across ring wraps.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // Descriptor format (fixed by the memory layout shared with software)
  localparam int LEN_W      = 16;
  localparam int STAT_W     = 16;
  localparam int DESC_BYTES = 8;
  localparam int PTR_OFS    = 4;
  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / 8;
  localparam int ALIGN_BITS = 3;

  // Status bit positions
  localparam int B_EMPTY = 15;
  localparam int B_WRAP  = 14;
  localparam int B_LAST  = 10;
  localparam int B_ERR   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HDR,
    ST_RD_PTR,
    ST_DECIDE,
    ST_FILL,
    ST_WBACK,
    ST_NEXT
  } seq_st_e;
endpackage

// File: rtl/rxbd_fill.sv
module rxbd_fill
  import rxbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] lim_in,
  input  logic             active,
  input  logic             take,
  input  logic             mark_last,
  input  logic             mark_err,
  input  logic             close_req,
  output logic [LEN_W-1:0] cnt_q,
  output logic             done,
  output logic             fin_last,
  output logic             fin_err
);
  logic [LEN_W-1:0] lim_q;
  logic             at_limit;
  logic             close_ok;

  assign at_limit = (cnt_q + LEN_W'(1)) == lim_q;
  assign close_ok = close_req && (take || cnt_q != '0);
  assign done     = active && ((take && (at_limit || mark_last || mark_err)) || close_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      lim_q    <= '0;
      fin_last <= 1'b0;
      fin_err  <= 1'b0;
    end else begin
      if (load) begin
        cnt_q    <= '0;
        lim_q    <= lim_in;
        fin_last <= 1'b0;
        fin_err  <= 1'b0;
      end else if (active && take) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
      if (done) begin
        fin_last <= take && mark_last;
        fin_err  <= take && mark_err;
      end
    end
  end

  // R4: while filling, the stored count is always below the latched limit
  a_r4_len_limit: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < lim_q));

  // R7: the latched limit does not move while a buffer is being filled
  a_r7_limit_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !done) |=> $stable(lim_q));
endmodule

// File: rtl/rxbd_port.sv
module rxbd_port
  import rxbd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  input  logic              cmd_wide,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [7:0]        cmd_byte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [DATA_W-1:0] wdata_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata_d[8*g +: 8] = cmd_wide ? cmd_word[8*g +: 8] : cmd_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req   <= cmd_valid;
      mem_we    <= cmd_valid && cmd_we;
      mem_addr  <= cmd_addr;
      mem_be    <= cmd_we ? cmd_be : '0;
      mem_wdata <= wdata_d;
    end
  end

  // R3: a write is either one byte lane or a full descriptor word
  a_r3_lane_write: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($onehot(mem_be) || mem_be == {LANES{1'b1}}));
endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
  import rxbd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [AW-1:0]     cfg_ring_base,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic [LEN_W-1:0]  cnt_q,
  input  logic              done,
  input  logic              fin_last,
  input  logic              fin_err,
  output logic              fill_active,
  output logic              load,
  output logic              in_ready,
  output logic              busy,
  output logic              wb_wrap,
  output logic [AW-1:0]     base_q,
  output logic              cmd_valid,
  output logic              cmd_we,
  output logic [AW-1:0]     cmd_addr,
  output logic [LANES-1:0]  cmd_be,
  output logic              cmd_wide,
  output logic [DATA_W-1:0] cmd_word
);
  localparam int LSB_W = $clog2(LANES);

  seq_st_e          st_q, st_d;
  logic [AW-1:0]    desc_q, desc_d;
  logic [STAT_W-1:0] stat_q;
  logic [AW-1:0]    ptr_q;
  logic             busy_q, busy_d;
  logic [AW-1:0]    base_in;
  logic [AW-1:0]    byte_addr;
  logic [STAT_W-1:0] stat_wb;

  assign base_in   = {cfg_ring_base[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign byte_addr = ptr_q + AW'(cnt_q);

  always_comb begin
    stat_wb         = stat_q;
    stat_wb[B_EMPTY] = 1'b0;
    stat_wb[B_LAST]  = fin_last;
    stat_wb[B_ERR]   = fin_err;
  end

  assign fill_active = (st_q == ST_FILL);
  assign in_ready    = fill_active || busy_q;
  assign busy        = busy_q;
  assign wb_wrap     = (st_q == ST_WBACK) && stat_q[B_WRAP];

  always_comb begin
    st_d      = st_q;
    desc_d    = desc_q;
    busy_d    = busy_q;
    load      = 1'b0;
    cmd_valid = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = desc_q;
    cmd_be    = '0;
    cmd_wide  = 1'b0;
    cmd_word  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_enable) begin
          desc_d    = base_in;
          cmd_valid = 1'b1;
          cmd_addr  = base_in;
          st_d      = ST_RD_HDR;
        end
      end
      ST_RD_HDR: begin
        cmd_valid = 1'b1;
        cmd_addr  = desc_q + AW'(PTR_OFS);
        st_d      = ST_RD_PTR;
      end
      ST_RD_PTR: st_d = ST_DECIDE;
      ST_DECIDE: begin
        if (stat_q[B_EMPTY]) begin
          load   = 1'b1;
          busy_d = 1'b0;
          st_d   = ST_FILL;
        end else begin
          busy_d    = 1'b1;
          cmd_valid = 1'b1;
          cmd_addr  = desc_q;
          st_d      = ST_RD_HDR;
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          cmd_valid = 1'b1;
          cmd_we    = 1'b1;
          cmd_addr  = {byte_addr[AW-1:LSB_W], {LSB_W{1'b0}}};
          cmd_be    = LANES'(1) << byte_addr[LSB_W-1:0];
        end
        if (done) st_d = ST_WBACK;
      end
      ST_WBACK: begin
        cmd_valid = 1'b1;
        cmd_we    = 1'b1;
        cmd_addr  = desc_q;
        cmd_be    = {LANES{1'b1}};
        cmd_wide  = 1'b1;
        cmd_word  = {cnt_q, stat_wb};
        st_d      = ST_NEXT;
      end
      ST_NEXT: begin
        desc_d    = stat_q[B_WRAP] ? base_q : desc_q + AW'(DESC_BYTES);
        cmd_valid = 1'b1;
        cmd_addr  = desc_d;
        st_d      = ST_RD_HDR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      desc_q <= '0;
      base_q <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      desc_q <= desc_d;
      busy_q <= busy_d;
      if (st_q == ST_IDLE)   base_q <= base_in;
      if (st_q == ST_RD_PTR) stat_q <= mem_rdata[STAT_W-1:0];
      if (st_q == ST_DECIDE) ptr_q  <= mem_rdata[AW-1:0];
    end
  end
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rxbd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [AW-1:0]     cfg_ring_base,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  input  logic              close_req,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              fill_active, load, done, fin_last, fin_err, wb_wrap;
  logic [LEN_W-1:0]  cnt_q;
  logic [AW-1:0]     base_q;
  logic              cmd_valid, cmd_we, cmd_wide;
  logic [AW-1:0]     cmd_addr;
  logic [LANES-1:0]  cmd_be;
  logic [DATA_W-1:0] cmd_word;

  rxbd_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
    .mem_rdata(mem_rdata), .in_valid(in_valid), .cnt_q(cnt_q), .done(done),
    .fin_last(fin_last), .fin_err(fin_err), .fill_active(fill_active), .load(load),
    .in_ready(in_ready), .busy(busy), .wb_wrap(wb_wrap), .base_q(base_q),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .cmd_wide(cmd_wide), .cmd_word(cmd_word)
  );

  rxbd_fill fill_i (
    .clk(clk), .rst(rst), .load(load), .lim_in(cfg_max_len), .active(fill_active),
    .take(in_valid && fill_active), .mark_last(in_last), .mark_err(in_err),
    .close_req(close_req), .cnt_q(cnt_q), .done(done), .fin_last(fin_last),
    .fin_err(fin_err)
  );

  rxbd_port #(.AW(AW)) port_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .cmd_wide(cmd_wide), .cmd_word(cmd_word), .cmd_byte(in_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata)
  );

  // R11: while no descriptor is owned, no memory write is issued
  a_r11_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(mem_req && mem_we));

  // R2: after write-back of a wrap descriptor, the next fetch goes to the base
  a_r2_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
    wb_wrap |-> ##2 (mem_req && !mem_we && mem_addr == base_q));
endmodule

// File: tb/rx_bd_ring_tb_top.sv
`timescale 1ns/1ps
module rx_bd_ring_tb_top;
  localparam int AW    = 12;
  localparam int BASE  = 'h40;
  localparam int NDESC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [AW-1:0] cfg_ring_base = AW'('h43);
  logic [15:0] cfg_max_len = 16'd8;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_err = 1'b0;
  logic        close_req = 1'b0;
  logic        in_ready, busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:(1<<(AW-2))-1];
  int total = 0;
  int bad = 0;
  int sw = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_bd_ring #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
    .cfg_max_len(cfg_max_len), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready), .close_req(close_req),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[AW-1:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[AW-1:2]];
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string msg, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  function automatic logic [15:0] armed(int i);
    return 16'h8021 | ((i == NDESC-1) ? 16'h4000 : 16'h0000);
  endfunction

  function automatic int bufp(int i);
    return 'h200 + 'h100 * i;
  endfunction

  function automatic int hdr(int i);
    return (BASE >> 2) + 2 * i;
  endfunction

  task automatic arm(int i);
    mem[hdr(i)]     = {16'h0, armed(i)};
    mem[hdr(i) + 1] = bufp(i);
    for (int w = 0; w < 16; w++) mem[(bufp(i) >> 2) + w] = 32'hEEEE_EEEE;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit lst, bit er, bit cls);
    int guard = 0;
    in_valid = 1'b1; in_data = d; in_last = lst; in_err = er; close_req = cls;
    while (!in_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) chk(0, "R11 input stalled", 0, 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; close_req = 1'b0;
  endtask

  task automatic send_frame(int n, int seed);
    for (int i = 0; i < n; i++) send(8'((seed + i) & 255), i == n - 1, 1'b0, 1'b0);
  endtask

  task automatic pulse_close();
    close_req = 1'b1;
    @(negedge clk);
    close_req = 1'b0;
  endtask

  // Checks the descriptor at the software index and its data, then re-arms it
  task automatic check_piece(string tag, int len, bit lst, bit er, int seed, int off);
    logic [31:0] got, exp;
    logic [15:0] st;
    int nbad = 0;
    int a;
    logic [7:0] b, e;
    st  = (armed(sw) & ~16'h8404) | (lst ? 16'h0400 : 16'h0) | (er ? 16'h0004 : 16'h0);
    exp = {16'(len), st};
    got = mem[hdr(sw)];
    chk(got == exp, $sformatf("%s R1 R2 R10 status word desc%0d", tag, sw), got, exp);
    for (int k = 0; k <= len && k < 64; k++) begin
      a = bufp(sw) + k;
      b = mem[a >> 2][8 * (a % 4) +: 8];
      e = (k == len) ? 8'hEE : 8'((seed + off + k) & 255);
      if (b != e) nbad++;
    end
    chk(nbad == 0, $sformatf("%s R3 buffer bytes desc%0d", tag, sw), nbad, 0);
    arm(sw);
    sw = (sw + 1) % NDESC;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int k, len;
    logic [31:0] snap;
    for (int i = 0; i < (1 << (AW - 2)); i++) mem[i] = '0;
    for (int i = 0; i < NDESC; i++) arm(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(mem_req == 0, "R12 mem_req after reset", mem_req, 0);
    chk(in_ready == 0, "R12 in_ready after reset", in_ready, 0);
    chk(busy == 0, "R12 busy after reset", busy, 0);
    idle(10);
    chk(mem_req == 0, "R1 no access while disabled", mem_req, 0);
    cfg_enable = 1'b1;
    idle(10);

    // R4 R5 sweep: every frame length up to three full buffers
    for (int n = 1; n <= 24; n++) begin
      send_frame(n, n * 5);
      idle(30);
      k = (n + 7) / 8;
      for (int p = 0; p < k; p++) begin
        len = (p < k - 1) ? 8 : n - 8 * (k - 1);
        check_piece($sformatf("R4 R5 n=%0d", n), len, p == k - 1, 1'b0, n * 5, 8 * p);
      end
      idle(20);
    end

    // R7: limit change during a held descriptor applies only later
    cfg_max_len = 16'd4;
    send_frame(12, 99);
    idle(30);
    check_piece("R7 old limit", 8, 1'b0, 1'b0, 99, 0);
    check_piece("R7 new limit", 4, 1'b1, 1'b0, 99, 8);
    idle(20);

    // R6: error marker
    send(8'h10, 0, 0, 0); send(8'h11, 0, 0, 0); send(8'h12, 0, 1, 0);
    idle(20);
    check_piece("R6 error close", 3, 1'b0, 1'b1, 'h10, 0);
    idle(20);

    // R8: close a partial buffer, then a close on an empty buffer is ignored
    send(8'h20, 0, 0, 0); send(8'h21, 0, 0, 0);
    idle(10);
    chk(mem[hdr(sw)] == {16'h0, armed(sw)}, "R8 partial buffer still open",
        mem[hdr(sw)], {16'h0, armed(sw)});
    pulse_close();
    idle(20);
    check_piece("R8 close partial", 2, 1'b0, 1'b0, 'h20, 0);
    idle(20);
    snap = mem[hdr(sw)];
    pulse_close();
    idle(20);
    chk(mem[hdr(sw)] == snap, "R8 empty close ignored", mem[hdr(sw)], snap);
    send_frame(3, 'h30);
    idle(20);
    check_piece("R8 reception continues", 3, 1'b1, 1'b0, 'h30, 0);
    idle(20);

    // R9: close together with the byte that reaches the limit
    send(8'h40, 0, 0, 0); send(8'h41, 0, 0, 0); send(8'h42, 0, 0, 0);
    send(8'h43, 0, 0, 1);
    idle(20);
    snap = mem[hdr((sw + 1) % NDESC)];
    check_piece("R9 close with limit byte", 4, 1'b0, 1'b0, 'h40, 0);
    chk(mem[hdr(sw)] == snap, "R9 single close at limit", mem[hdr(sw)], snap);
    send_frame(2, 'h50);
    idle(20);
    check_piece("R9 next after limit close", 2, 1'b1, 1'b0, 'h50, 0);
    idle(20);

    // R9: close together with the frame-end byte
    send(8'h60, 0, 0, 0); send(8'h61, 1, 0, 1);
    idle(20);
    check_piece("R9 close with last byte", 2, 1'b1, 1'b0, 'h60, 0);
    send_frame(1, 'h70);
    idle(20);
    check_piece("R9 next after last close", 1, 1'b1, 1'b0, 'h70, 0);
    idle(20);

    // R11: no empty descriptor ahead
    snap = {16'h0, armed((sw + 1) % NDESC) & 16'h7FFF};
    mem[hdr((sw + 1) % NDESC)] = snap;
    mem[hdr((sw + 2) % NDESC)] = {16'h0, armed((sw + 2) % NDESC) & 16'h7FFF};
    send_frame(3, 'h80);
    idle(20);
    chk(busy == 1, "R11 busy raised", busy, 1);
    chk(in_ready == 1, "R11 in_ready while busy", in_ready, 1);
    for (int i = 0; i < 5; i++) send(8'h55, 0, 0, 0);
    idle(10);
    chk(mem[hdr((sw + 1) % NDESC)] == snap, "R11 owned descriptor untouched",
        mem[hdr((sw + 1) % NDESC)], snap);
    check_piece("R11 frame before busy", 3, 1'b1, 1'b0, 'h80, 0);
    arm(sw);
    idle(20);
    chk(busy == 0, "R11 busy cleared after release", busy, 0);
    send_frame(3, 'h90);
    idle(20);
    check_piece("R11 resumed frame", 3, 1'b1, 1'b0, 'h90, 0);
    arm(sw);
    idle(20);
    summary();
  end
endmodule